// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This unit performs the register-side work of taking a processor exception. A request strobe arrives with the kind of exception and a snapshot of the context: the current PC, whether the faulting instruction sits in a branch delay slot, the boot-vector status bit, the cause register, the TLB refill flag and the current mode flags (exception level, error level, debug mode). One clock later the unit presents the handler address and the writes that the register file must commit.

Exceptions fall into three classes, and each class has its own return register and its own vector. General exceptions store their return PC in EPC and put their exception code into the cause register. The reset class (power-on reset, soft reset, NMI) uses ErrorEPC, a fixed boot vector and a new status word. The debug class uses DEPC, a fixed debug vector and a one-hot debug-cause set mask. An unrecognised kind raises an error pulse and changes nothing. Choosing between several pending exceptions is the job of the logic in front of this unit.

Top module: `exc_entry_unit`

## Requirements
- R1: A request with a recognised kind produces `done_o` high for exactly one cycle, in the cycle after the request. Write enables, `watch_clr_o` and `dslot_clr_o` pulse only in that cycle. After reset every output is zero.
- R2: A general exception (kinds 0 to 15) vectors to base + 0x180. The base is 0xBFC00200 when `status_bev_i` is 1 and 0x80000000 when it is 0.
- R3: An interrupt (kind 0, debug mode clear) uses offset 0x200 when cause bit 23 is set, and 0x180 otherwise.
- R4: A TLB load (kind 2) or TLB store (kind 3) with `refill_i` high and `exl_i` low uses offset 0x000. With `exl_i` high, or for any other kind, the refill flag has no effect.
- R5: A general exception writes the cause register with bits 6:2 replaced by the code for its kind, and all bits other than 31 and 6:2 copied from `cause_i`. The codes by kind are: 0→0, 1→1, 2→2, 3→3, 4→4, 5→4, 6→6, 7→7, 8→8, 9→9, 10→10, 11→11, 12→12, 13→13, 14→23, 15→24.
- R6: For a general exception in a delay slot, EPC is PC−4 and cause bit 31 is 1. Outside a delay slot, EPC is PC and bit 31 is 0. The entry pulses `dslot_clr_o`, sets EXL and keeps ERL and DM.
- R7: Reset (16), soft reset (17) and NMI (18) vector to 0xBFC00000 and write ErrorEPC with the delay-corrected PC. The mode becomes ERL=1, EXL=0, DM=0, and `dslot_clr_o` pulses.
- R8: The reset class writes a status word with only bit 28 (CU0) and bit 22 (BEV) set. Soft reset adds bit 20 and NMI adds bit 19. `watch_clr_o` pulses for reset and soft reset but not for NMI.
- R9: The debug kinds vector to 0xBFC00480, set DM and keep EXL and ERL. The kinds are single step (19), interrupt (20), instruction break (21), breakpoint (22), data load break (23) and data store break (24). The entry writes one `dbg_set_o` bit: bit 0 step, 5 interrupt, 4 instruction break, 1 breakpoint, 2 load, 3 store. DEPC takes the delay-corrected PC and `dslot_clr_o` pulses, except for single step, which saves PC unchanged and does not pulse `dslot_clr_o`.
- R10: An interrupt (kind 0) requested while `dm_i` is 1 is handled exactly as a debug interrupt (kind 20).
- R11: A kind of 25 to 31 pulses `err_o` for one cycle. It asserts no write enable, and `new_pc_o` and all data outputs keep their previous values.
- R12: At most one of the three return-PC write enables is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one cycle per exception |
| kind_i | input | 5 | Exception kind |
| refill_i | input | 1 | TLB miss had no matching entry |
| pc_i | input | 32 | PC of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction is in a delay slot |
| status_bev_i | input | 1 | Boot-exception-vector status bit |
| cause_i | input | 32 | Current cause register |
| exl_i | input | 1 | Current exception-level flag |
| erl_i | input | 1 | Current error-level flag |
| dm_i | input | 1 | Current debug-mode flag |
| done_o | output | 1 | Entry completed |
| err_o | output | 1 | Unrecognised kind |
| new_pc_o | output | 32 | Handler address |
| epc_we_o | output | 1 | EPC write |
| epc_o | output | 32 | EPC value |
| errepc_we_o | output | 1 | ErrorEPC write |
| errepc_o | output | 32 | ErrorEPC value |
| depc_we_o | output | 1 | DEPC write |
| depc_o | output | 32 | DEPC value |
| cause_we_o | output | 1 | Cause write |
| cause_o | output | 32 | Cause value |
| status_we_o | output | 1 | Status write |
| status_o | output | 32 | Status value |
| watch_clr_o | output | 1 | Clear watch-low register |
| dslot_clr_o | output | 1 | Clear delay-slot flag |
| dbg_set_o | output | 6 | Debug-cause bits to set |
| mode_we_o | output | 1 | Mode flags write |
| exl_o | output | 1 | New exception level |
| erl_o | output | 1 | New error level |
| dm_o | output | 1 | New debug mode |

## Verification
Two functions can fall into the same request. The first is the interrupt redirect into debug mode, which collides with the interrupt-vector offset. The second is the TLB refill offset, which collides with an exception level that is already set. The bench provokes both collisions directly. It requests an interrupt with cause bit 23 set while `dm_i` is high, and expects the debug vector, DEPC and debug-cause bit 5 instead of offset 0x200. It requests refill TLB faults with `exl_i` both low and high, and expects 0x000 only in the first case. The random phase then draws every input independently, so these overlaps and the delay-slot correction recur many times. Each result is compared with a bench model written from the requirements.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int CODE_W = 5;
    localparam int DBG_W  = 6;

    // status and cause bit positions used by neighbours
    localparam int ST_CU0   = 28;
    localparam int ST_BEV   = 22;
    localparam int ST_SOFT  = 20;
    localparam int ST_NMI   = 19;
    localparam int CA_BD    = 31;
    localparam int CA_IV    = 23;
    localparam int CA_CODE_LO = 2;
    localparam int CA_CODE_HI = CA_CODE_LO + CODE_W - 1;

    typedef enum logic [4:0] {
        K_INT       = 5'd0,
        K_TLB_MOD   = 5'd1,
        K_TLB_LOAD  = 5'd2,
        K_TLB_STORE = 5'd3,
        K_ADDR_LOAD = 5'd4,
        K_ADDR_STOR = 5'd5,
        K_IBUS      = 5'd6,
        K_DBUS      = 5'd7,
        K_SYSCALL   = 5'd8,
        K_BREAK     = 5'd9,
        K_RESVD     = 5'd10,
        K_COPROC    = 5'd11,
        K_OVF       = 5'd12,
        K_TRAP      = 5'd13,
        K_WATCH     = 5'd14,
        K_MCHECK    = 5'd15,
        K_RESET     = 5'd16,
        K_SRESET    = 5'd17,
        K_NMI       = 5'd18,
        K_DSTEP     = 5'd19,
        K_DINT      = 5'd20,
        K_DIBRK     = 5'd21,
        K_DBRK      = 5'd22,
        K_DLOAD     = 5'd23,
        K_DSTORE    = 5'd24
    } exc_kind_e;

    typedef enum logic [1:0] {
        CLS_GEN = 2'd0,
        CLS_ERR = 2'd1,
        CLS_DBG = 2'd2,
        CLS_BAD = 2'd3
    } exc_class_e;

    typedef struct packed {
        logic              done;
        logic              err;
        logic [XLEN-1:0]   pc;
        logic              epc_we;
        logic [XLEN-1:0]   epc;
        logic              eepc_we;
        logic [XLEN-1:0]   eepc;
        logic              depc_we;
        logic [XLEN-1:0]   depc;
        logic              cause_we;
        logic [XLEN-1:0]   cause;
        logic              stat_we;
        logic [XLEN-1:0]   stat;
        logic              wclr;
        logic              dsclr;
        logic [DBG_W-1:0]  dbg;
        logic              mode_we;
        logic              exl;
        logic              erl;
        logic              dm;
    } entry_regs_t;

endpackage

// File: rtl/exc_decode.sv
module exc_decode
    import exc_entry_pkg::*;
(
    input  logic [4:0]        kind_i,
    input  logic              dm_i,
    output exc_class_e        cls_o,
    output logic [CODE_W-1:0] code_o,
    output logic [DBG_W-1:0]  dbg_hot_o,
    output logic              is_int_o,
    output logic              is_tlb_o,
    output logic              is_step_o,
    output logic              st_soft_o,
    output logic              st_nmi_o,
    output logic              clr_watch_o
);

    exc_kind_e kind;

    always_comb begin
        kind = exc_kind_e'(kind_i);
        // an interrupt seen in debug mode becomes a debug interrupt
        if (kind == K_INT && dm_i) begin
            kind = K_DINT;
        end
    end

    always_comb begin
        cls_o       = CLS_GEN;
        code_o      = '0;
        dbg_hot_o   = '0;
        is_int_o    = 1'b0;
        is_tlb_o    = 1'b0;
        is_step_o   = 1'b0;
        st_soft_o   = 1'b0;
        st_nmi_o    = 1'b0;
        clr_watch_o = 1'b0;
        unique case (kind)
            K_INT:       begin code_o = 5'd0; is_int_o = 1'b1; end
            K_TLB_MOD:   code_o = 5'd1;
            K_TLB_LOAD:  begin code_o = 5'd2; is_tlb_o = 1'b1; end
            K_TLB_STORE: begin code_o = 5'd3; is_tlb_o = 1'b1; end
            K_ADDR_LOAD,
            K_ADDR_STOR: code_o = 5'd4;
            K_IBUS:      code_o = 5'd6;
            K_DBUS:      code_o = 5'd7;
            K_SYSCALL:   code_o = 5'd8;
            K_BREAK:     code_o = 5'd9;
            K_RESVD:     code_o = 5'd10;
            K_COPROC:    code_o = 5'd11;
            K_OVF:       code_o = 5'd12;
            K_TRAP:      code_o = 5'd13;
            K_WATCH:     code_o = 5'd23;
            K_MCHECK:    code_o = 5'd24;
            K_RESET:     begin cls_o = CLS_ERR; clr_watch_o = 1'b1; end
            K_SRESET:    begin cls_o = CLS_ERR; clr_watch_o = 1'b1; st_soft_o = 1'b1; end
            K_NMI:       begin cls_o = CLS_ERR; st_nmi_o = 1'b1; end
            K_DSTEP:     begin cls_o = CLS_DBG; dbg_hot_o[0] = 1'b1; is_step_o = 1'b1; end
            K_DBRK:      begin cls_o = CLS_DBG; dbg_hot_o[1] = 1'b1; end
            K_DLOAD:     begin cls_o = CLS_DBG; dbg_hot_o[2] = 1'b1; end
            K_DSTORE:    begin cls_o = CLS_DBG; dbg_hot_o[3] = 1'b1; end
            K_DIBRK:     begin cls_o = CLS_DBG; dbg_hot_o[4] = 1'b1; end
            K_DINT:      begin cls_o = CLS_DBG; dbg_hot_o[5] = 1'b1; end
            default:     cls_o = CLS_BAD;
        endcase
    end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] ERR_VEC    = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] DBG_VEC    = 32'hBFC0_0480,
    parameter logic [XLEN-1:0] OFS_GEN    = 32'h0000_0180,
    parameter logic [XLEN-1:0] OFS_INT    = 32'h0000_0200,
    parameter logic [XLEN-1:0] OFS_REFILL = 32'h0000_0000
) (
    input  exc_class_e       cls_i,
    input  logic             bev_i,
    input  logic             iv_i,
    input  logic             is_int_i,
    input  logic             is_tlb_i,
    input  logic             refill_i,
    input  logic             exl_i,
    output logic [XLEN-1:0]  vec_o
);

    logic [XLEN-1:0] ofs;
    logic [XLEN-1:0] base;

    always_comb begin
        ofs = OFS_GEN;
        if (is_int_i && iv_i) begin
            ofs = OFS_INT;
        end else if (is_tlb_i && refill_i && !exl_i) begin
            ofs = OFS_REFILL;
        end
        base = bev_i ? BOOT_BASE : RUN_BASE;
        unique case (cls_i)
            CLS_GEN: vec_o = base + ofs;
            CLS_ERR: vec_o = ERR_VEC;
            CLS_DBG: vec_o = DBG_VEC;
            default: vec_o = '0;
        endcase
    end

endmodule

// File: rtl/exc_return.sv
module exc_return
    import exc_entry_pkg::*;
#(
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            in_dslot_i,
    input  logic            no_fix_i,
    output logic [XLEN-1:0] ret_o
);

    localparam logic [XLEN-1:0] STEP_BACK = XLEN'(INSN_BYTES);

    always_comb begin
        if (in_dslot_i && !no_fix_i) begin
            ret_o = pc_i - STEP_BACK;
        end else begin
            ret_o = pc_i;
        end
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] ERR_VEC   = 32'hBFC0_0000,
    parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
    parameter logic [31:0] RUN_BASE  = 32'h8000_0000,
    parameter logic [31:0] DBG_VEC   = 32'hBFC0_0480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic [4:0]  kind_i,
    input  logic        refill_i,
    input  logic [31:0] pc_i,
    input  logic        in_dslot_i,
    input  logic        status_bev_i,
    input  logic [31:0] cause_i,
    input  logic        exl_i,
    input  logic        erl_i,
    input  logic        dm_i,
    output logic        done_o,
    output logic        err_o,
    output logic [31:0] new_pc_o,
    output logic        epc_we_o,
    output logic [31:0] epc_o,
    output logic        errepc_we_o,
    output logic [31:0] errepc_o,
    output logic        depc_we_o,
    output logic [31:0] depc_o,
    output logic        cause_we_o,
    output logic [31:0] cause_o,
    output logic        status_we_o,
    output logic [31:0] status_o,
    output logic        watch_clr_o,
    output logic        dslot_clr_o,
    output logic [5:0]  dbg_set_o,
    output logic        mode_we_o,
    output logic        exl_o,
    output logic        erl_o,
    output logic        dm_o
);

    exc_class_e        cls;
    logic [CODE_W-1:0] code;
    logic [DBG_W-1:0]  dbg_hot;
    logic              is_int, is_tlb, is_step;
    logic              st_soft, st_nmi, clr_watch;
    logic [XLEN-1:0]   vec;
    logic [XLEN-1:0]   ret_pc;

    exc_decode u_decode (
        .kind_i      (kind_i),
        .dm_i        (dm_i),
        .cls_o       (cls),
        .code_o      (code),
        .dbg_hot_o   (dbg_hot),
        .is_int_o    (is_int),
        .is_tlb_o    (is_tlb),
        .is_step_o   (is_step),
        .st_soft_o   (st_soft),
        .st_nmi_o    (st_nmi),
        .clr_watch_o (clr_watch)
    );

    exc_vector #(
        .ERR_VEC   (ERR_VEC),
        .BOOT_BASE (BOOT_BASE),
        .RUN_BASE  (RUN_BASE),
        .DBG_VEC   (DBG_VEC)
    ) u_vector (
        .cls_i    (cls),
        .bev_i    (status_bev_i),
        .iv_i     (cause_i[CA_IV]),
        .is_int_i (is_int),
        .is_tlb_i (is_tlb),
        .refill_i (refill_i),
        .exl_i    (exl_i),
        .vec_o    (vec)
    );

    exc_return u_return (
        .pc_i       (pc_i),
        .in_dslot_i (in_dslot_i),
        .no_fix_i   (is_step),
        .ret_o      (ret_pc)
    );

    entry_regs_t regs_d, regs_q;

    always_comb begin
        regs_d          = regs_q;
        regs_d.done     = 1'b0;
        regs_d.err      = 1'b0;
        regs_d.epc_we   = 1'b0;
        regs_d.eepc_we  = 1'b0;
        regs_d.depc_we  = 1'b0;
        regs_d.cause_we = 1'b0;
        regs_d.stat_we  = 1'b0;
        regs_d.wclr     = 1'b0;
        regs_d.dsclr    = 1'b0;
        regs_d.dbg      = '0;
        regs_d.mode_we  = 1'b0;
        if (req_i) begin
            unique case (cls)
                CLS_GEN: begin
                    regs_d.done     = 1'b1;
                    regs_d.pc       = vec;
                    regs_d.epc_we   = 1'b1;
                    regs_d.epc      = ret_pc;
                    regs_d.cause_we = 1'b1;
                    regs_d.cause    = cause_i;
                    regs_d.cause[CA_CODE_HI:CA_CODE_LO] = code;
                    regs_d.cause[CA_BD] = in_dslot_i;
                    regs_d.dsclr    = 1'b1;
                    regs_d.mode_we  = 1'b1;
                    regs_d.exl      = 1'b1;
                    regs_d.erl      = erl_i;
                    regs_d.dm       = dm_i;
                end
                CLS_ERR: begin
                    regs_d.done     = 1'b1;
                    regs_d.pc       = vec;
                    regs_d.eepc_we  = 1'b1;
                    regs_d.eepc     = ret_pc;
                    regs_d.stat_we  = 1'b1;
                    regs_d.stat     = '0;
                    regs_d.stat[ST_CU0]  = 1'b1;
                    regs_d.stat[ST_BEV]  = 1'b1;
                    regs_d.stat[ST_SOFT] = st_soft;
                    regs_d.stat[ST_NMI]  = st_nmi;
                    regs_d.wclr     = clr_watch;
                    regs_d.dsclr    = 1'b1;
                    regs_d.mode_we  = 1'b1;
                    regs_d.exl      = 1'b0;
                    regs_d.erl      = 1'b1;
                    regs_d.dm       = 1'b0;
                end
                CLS_DBG: begin
                    regs_d.done     = 1'b1;
                    regs_d.pc       = vec;
                    regs_d.depc_we  = 1'b1;
                    regs_d.depc     = ret_pc;
                    regs_d.dbg      = dbg_hot;
                    regs_d.dsclr    = !is_step;
                    regs_d.mode_we  = 1'b1;
                    regs_d.exl      = exl_i;
                    regs_d.erl      = erl_i;
                    regs_d.dm       = 1'b1;
                end
                default: begin
                    regs_d.err      = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign done_o      = regs_q.done;
    assign err_o       = regs_q.err;
    assign new_pc_o    = regs_q.pc;
    assign epc_we_o    = regs_q.epc_we;
    assign epc_o       = regs_q.epc;
    assign errepc_we_o = regs_q.eepc_we;
    assign errepc_o    = regs_q.eepc;
    assign depc_we_o   = regs_q.depc_we;
    assign depc_o      = regs_q.depc;
    assign cause_we_o  = regs_q.cause_we;
    assign cause_o     = regs_q.cause;
    assign status_we_o = regs_q.stat_we;
    assign status_o    = regs_q.stat;
    assign watch_clr_o = regs_q.wclr;
    assign dslot_clr_o = regs_q.dsclr;
    assign dbg_set_o   = regs_q.dbg;
    assign mode_we_o   = regs_q.mode_we;
    assign exl_o       = regs_q.exl;
    assign erl_o       = regs_q.erl;
    assign dm_o        = regs_q.dm;

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (done_o ^ err_o)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !(done_o || err_o || mode_we_o || cause_we_o || status_we_o)); // R1

    AST_BD_TRACKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we_o |-> (cause_o[31] == $past(in_dslot_i))); // R6

    AST_EPC_NEAR_PC: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we_o |-> (epc_o == $past(pc_i) || epc_o == $past(pc_i) - 32'd4)); // R6

    AST_ERR_CLASS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        errepc_we_o |-> (new_pc_o == ERR_VEC && erl_o && !exl_o)); // R7

    AST_DBG_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        depc_we_o |-> (dm_o && $countones(dbg_set_o) == 1)); // R9

    AST_BAD_KIND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(new_pc_o) && !mode_we_o && !done_o)); // R11

    AST_ONE_RETURN_REG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({epc_we_o, errepc_we_o, depc_we_o})); // R12

endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
    import exc_entry_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [4:0]  kind_i = '0;
    logic        refill_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        in_dslot_i = 1'b0;
    logic        status_bev_i = 1'b0;
    logic [31:0] cause_i = '0;
    logic        exl_i = 1'b0, erl_i = 1'b0, dm_i = 1'b0;
    logic        done_o, err_o, epc_we_o, errepc_we_o, depc_we_o;
    logic        cause_we_o, status_we_o, watch_clr_o, dslot_clr_o;
    logic        mode_we_o, exl_o, erl_o, dm_o;
    logic [31:0] new_pc_o, epc_o, errepc_o, depc_o, cause_o, status_o;
    logic [5:0]  dbg_set_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    entry_regs_t exp_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit u_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
        .refill_i(refill_i), .pc_i(pc_i), .in_dslot_i(in_dslot_i),
        .status_bev_i(status_bev_i), .cause_i(cause_i),
        .exl_i(exl_i), .erl_i(erl_i), .dm_i(dm_i),
        .done_o(done_o), .err_o(err_o), .new_pc_o(new_pc_o),
        .epc_we_o(epc_we_o), .epc_o(epc_o),
        .errepc_we_o(errepc_we_o), .errepc_o(errepc_o),
        .depc_we_o(depc_we_o), .depc_o(depc_o),
        .cause_we_o(cause_we_o), .cause_o(cause_o),
        .status_we_o(status_we_o), .status_o(status_o),
        .watch_clr_o(watch_clr_o), .dslot_clr_o(dslot_clr_o),
        .dbg_set_o(dbg_set_o), .mode_we_o(mode_we_o),
        .exl_o(exl_o), .erl_o(erl_o), .dm_o(dm_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] code_of(input logic [4:0] k);
        case (k)
            5'd5:  return 5'd4;
            5'd14: return 5'd23;
            5'd15: return 5'd24;
            default: return k;
        endcase
    endfunction

    // expected registers after one request, built from the requirements
    function automatic entry_regs_t model(input entry_regs_t p, input logic [4:0] k_in,
                                          input logic rf, input logic [31:0] pc,
                                          input logic ds, input logic bev,
                                          input logic [31:0] ca, input logic exl,
                                          input logic erl, input logic dm);
        entry_regs_t r;
        logic [4:0] k;
        logic [31:0] ofs;
        r = p;
        r.done = 0; r.err = 0; r.epc_we = 0; r.eepc_we = 0; r.depc_we = 0;
        r.cause_we = 0; r.stat_we = 0; r.wclr = 0; r.dsclr = 0; r.dbg = '0; r.mode_we = 0;
        k = (k_in == 5'd0 && dm) ? 5'd20 : k_in;
        if (k <= 5'd15) begin
            ofs = 32'h180;
            if (k == 5'd0 && ca[23]) ofs = 32'h200;
            else if ((k == 5'd2 || k == 5'd3) && rf && !exl) ofs = 32'h0;
            r.done = 1; r.pc = (bev ? 32'hBFC0_0200 : 32'h8000_0000) + ofs;
            r.epc_we = 1; r.epc = ds ? pc - 32'd4 : pc;
            r.cause_we = 1; r.cause = {ds, ca[30:7], code_of(k), ca[1:0]};
            r.dsclr = 1; r.mode_we = 1; r.exl = 1; r.erl = erl; r.dm = dm;
        end else if (k <= 5'd18) begin
            r.done = 1; r.pc = 32'hBFC0_0000;
            r.eepc_we = 1; r.eepc = ds ? pc - 32'd4 : pc;
            r.stat_we = 1;
            r.stat = 32'h1040_0000 | ((k == 5'd17) ? 32'h0010_0000 : 32'h0)
                                   | ((k == 5'd18) ? 32'h0008_0000 : 32'h0);
            r.wclr = (k != 5'd18); r.dsclr = 1;
            r.mode_we = 1; r.exl = 0; r.erl = 1; r.dm = 0;
        end else if (k <= 5'd24) begin
            r.done = 1; r.pc = 32'hBFC0_0480;
            r.depc_we = 1; r.depc = (ds && k != 5'd19) ? pc - 32'd4 : pc;
            case (k)
                5'd19: r.dbg = 6'b000001;
                5'd20: r.dbg = 6'b100000;
                5'd21: r.dbg = 6'b010000;
                5'd22: r.dbg = 6'b000010;
                5'd23: r.dbg = 6'b000100;
                default: r.dbg = 6'b001000;
            endcase
            r.dsclr = (k != 5'd19);
            r.mode_we = 1; r.exl = exl; r.erl = erl; r.dm = 1;
        end else begin
            r.err = 1;
        end
        return r;
    endfunction

    task automatic op(input logic [4:0] k, input logic rf, input logic [31:0] pc,
                      input logic ds, input logic bev, input logic [31:0] ca,
                      input logic exl, input logic erl, input logic dm);
        entry_regs_t e;
        string pt;
        req_i = 1; kind_i = k; refill_i = rf; pc_i = pc; in_dslot_i = ds;
        status_bev_i = bev; cause_i = ca; exl_i = exl; erl_i = erl; dm_i = dm;
        e = model(exp_q, k, rf, pc, ds, bev, ca, exl, erl, dm);
        exp_q = e;
        @(negedge clk);
        req_i = 0;
        if (e.err) pt = "R11 pc held";
        else if (e.depc_we) pt = "R9 debug vector";
        else if (e.eepc_we) pt = "R7 reset vector";
        else if (k == 5'd0) pt = "R3 interrupt vector";
        else if (k == 5'd2 || k == 5'd3) pt = "R4 tlb vector";
        else pt = "R2 general vector";
        chk("R1 done", done_o, e.done);
        chk("R11 err", err_o, e.err);
        chk(pt, new_pc_o, e.pc);
        chk("R12 write enables", {epc_we_o, errepc_we_o, depc_we_o, cause_we_o, status_we_o, mode_we_o},
            {e.epc_we, e.eepc_we, e.depc_we, e.cause_we, e.stat_we, e.mode_we});
        chk("R6 epc", epc_o, e.epc);
        chk("R7 errorepc", errepc_o, e.eepc);
        chk("R9 depc", depc_o, e.depc);
        chk("R5 cause", cause_o, e.cause);
        chk("R8 status", status_o, e.stat);
        chk("R8 watch clear", watch_clr_o, e.wclr);
        chk("R6 slot clear", dslot_clr_o, e.dsclr);
        chk("R9 debug cause", dbg_set_o, e.dbg);
        chk("R7 mode flags", {exl_o, erl_o, dm_o}, {e.exl, e.erl, e.dm});
        if (k == 5'd0 && dm) chk("R10 interrupt in debug mode", {depc_we_o, dbg_set_o[5]}, 2'b11);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R1 idle done", {done_o, err_o, mode_we_o, epc_we_o, dslot_clr_o}, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_q = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {done_o, err_o, new_pc_o[0], mode_we_o, dm_o, erl_o}, '0);
        chk("R1 reset pc", new_pc_o, 32'h0);
        rst_n = 1;
        @(negedge clk);
        // directed corners
        op(5'd8,  0, 32'h0000_1000, 0, 1, 32'h0, 0, 0, 0);          // R2 boot base
        op(5'd12, 0, 32'h0040_0010, 0, 0, 32'h0, 0, 0, 0);          // R2 run base
        op(5'd0,  0, 32'h0040_0020, 0, 0, 32'h0080_0000, 0, 0, 0);  // R3 IV set
        op(5'd0,  0, 32'h0040_0024, 0, 0, 32'h0, 0, 0, 0);          // R3 IV clear
        op(5'd2,  1, 32'h0040_0030, 0, 0, 32'h0, 0, 0, 0);          // R4 refill
        op(5'd3,  1, 32'h0040_0034, 0, 0, 32'h0, 1, 0, 0);          // R4 refill blocked by EXL
        op(5'd3,  1, 32'h0040_0038, 0, 1, 32'h0, 0, 0, 0);          // R4 refill boot base
        op(5'd1,  1, 32'h0040_003C, 0, 0, 32'h0, 0, 0, 0);          // R4 modify ignores refill
        op(5'd14, 0, 32'h0040_0040, 1, 0, 32'hFFFF_FFFF, 0, 1, 0);  // R5 R6 slot
        op(5'd15, 0, 32'h0040_0044, 0, 0, 32'hFFFF_FFFF, 0, 0, 0);  // R5
        idle_check();
        op(5'd16, 0, 32'h0040_0050, 1, 0, 32'h0, 1, 0, 1);          // R7 R8 reset
        op(5'd17, 0, 32'h0040_0054, 0, 0, 32'h0, 0, 0, 0);          // R8 soft reset
        op(5'd18, 0, 32'h0040_0058, 1, 1, 32'h0, 0, 0, 0);          // R8 NMI
        op(5'd19, 0, 32'h0040_0060, 1, 0, 32'h0, 1, 0, 0);          // R9 step no fix
        op(5'd22, 0, 32'h0040_0064, 1, 0, 32'h0, 0, 1, 0);          // R9 break fixed
        op(5'd0,  0, 32'h0040_0068, 0, 0, 32'h0080_0000, 0, 0, 1);  // R10
        op(5'd25, 0, 32'h1234_5678, 1, 1, 32'h0, 0, 0, 0);          // R11
        op(5'd31, 1, 32'h8765_4321, 0, 0, 32'h0, 1, 1, 1);          // R11
        idle_check();
        for (int i = 0; i < 800; i++) begin
            op(5'($urandom_range(0, 31)), 1'($urandom), $urandom, 1'($urandom),
               1'($urandom), $urandom, 1'($urandom), 1'($urandom),
               ($urandom_range(0, 3) == 0));
            if ((i % 50) == 0) idle_check();
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule